// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the system side of a byte-wide parallel flash and turns a single host request into the write-cycle sequence the flash expects. Three request kinds are accepted: program one byte, erase a chosen set of sectors (given as a bit mask), and erase the whole chip. The block issues the unlock and command writes itself, then reads the flash status byte in a loop until the operation finishes, the flash signals an internal failure, or a host-side poll limit runs out. The outcome comes back as a one-cycle completion pulse with error and timeout flags.

The flash is reached over a simple synchronous bus: a one-cycle write strobe with address and data, and a one-cycle read strobe whose data is presented by the flash on `fl_rdata` in the following cycle. Before programming, the sequencer reads the target byte and refuses the request if it would need any bit to go from 0 to 1, since only an erase can do that. When a failure or timeout leaves the flash in an unknown internal state, the sequencer writes a reset command so the flash returns to normal reads.

Top module: `flseq_top`

## Requirements
- R1: After reset, and whenever `req_ready` is high, the block is idle: `req_ready`=1, `done`=0, and neither `fl_we` nor `fl_rd` is asserted.
- R2: A program request (`req_op`=2'b00) first reads the target address once, then issues exactly four writes (address/data): 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then the request address/data. Unlock addresses are zero-extended to `ADDR_W` bits. Read and write strobes are never high together.
- R3: A request is refused with `done`=1, `err`=1, `tmo`=0 and no write on the bus when: it is a program whose prior byte P and data D have (P & D) != D; it is a sector erase (`req_op`=2'b01) with an all-zero mask; or `req_op`=2'b11, in which case `done` and `err` appear the cycle after acceptance.
- R4: A sector erase issues 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, then one 0x30 write per selected sector in ascending sector order, each to that sector's base address (sector index in the top `log2(NSECT)` address bits, rest zero). Consecutive 0x30 writes are exactly two cycles apart. Unselected sectors keep their contents.
- R5: A chip erase (`req_op`=2'b10) issues the same five-write prefix followed by 0x5555/0x10.
- R6: After the last command write, the block reads a poll address repeatedly: the programmed address for a program, the base of the lowest selected sector for a sector erase, and address 0 for a chip erase. A program completes when bit 7 of the read byte equals bit 7 of the programmed data; an erase completes when bit 7 reads 1. Completion gives `done`=1 with `err`=0, `tmo`=0 and no further writes.
- R7: If a poll read is not complete and has bit 5 set, the block reads once more; if that read is complete the result is success, otherwise it writes 0xF0 to address 0 and ends with `err`=1, `tmo`=0.
- R8: If `MAX_POLLS` poll reads in a row are neither complete nor show bit 5, the block writes 0xF0 to address 0 and ends with `tmo`=1, `err`=0.
- R9: While an operation runs, `req_ready` is 0 and `req_valid` is ignored: the bus sequence is unchanged by requests presented meanwhile.
- R10: `done` is a single-cycle pulse; `err` and `tmo` are only high with `done` and never together; `req_ready` is high in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle; a request is taken when both are high |
| req_op | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| req_addr | input | ADDR_W | Byte address for a program |
| req_data | input | 8 | Byte to program |
| req_mask | input | NSECT | Sectors to erase, bit i selects sector i |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Operation refused or failed (with done) |
| tmo | output | 1 | Host poll limit reached (with done) |
| fl_we | output | 1 | Flash write strobe |
| fl_rd | output | 1 | Flash read strobe |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, valid the cycle after `fl_rd` |

## Verification
The embedded properties assume the flash answers a read strobe with a byte in the very next cycle and that `req_op`, `req_addr`, `req_data` and `req_mask` are stable while `req_valid` is high in an idle cycle. The bench's flash stub registers its read data on the strobe edge, so the first assumption holds by construction, and requests are driven on falling edges and held for exactly one full cycle. Stray requests during a running operation are driven deliberately, which the properties permit since they only constrain accepted requests.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_CHIP = 2'b10,
        OP_RSVD = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_PRE_RD, S_PRE_CHK, S_WR, S_GAP,
        S_POLL_RD, S_POLL_CHK, S_RCK_RD, S_RCK_CHK, S_RST_WR, S_FIN
    } state_e;

    localparam logic [14:0] UNLK_HI = 15'h5555;
    localparam logic [14:0] UNLK_LO = 15'h2AAA;

    localparam logic [7:0] CMD_KEY1  = 8'hAA;
    localparam logic [7:0] CMD_KEY2  = 8'h55;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_ESET  = 8'h80;
    localparam logic [7:0] CMD_CHIP  = 8'h10;
    localparam logic [7:0] CMD_SECT  = 8'h30;
    localparam logic [7:0] CMD_RESET = 8'hF0;

    localparam logic [2:0] STEP_TAIL = 3'd5;

    // Status byte says the operation has finished.
    function automatic logic poll_done(op_e op, logic [7:0] rd, logic [7:0] want);
        return (op == OP_PROG) ? (rd[7] == want[7]) : rd[7];
    endfunction

    // A 1 is requested where the cell already holds 0.
    function automatic logic needs_set(logic [7:0] prior, logic [7:0] want);
        return (prior & want) != want;
    endfunction

endpackage

// File: rtl/flseq_sectpick.sv
module flseq_sectpick
    import flseq_pkg::*;
#(
    parameter int NSECT = 8,
    parameter int IDX_W = $clog2(NSECT)
) (
    input  logic [NSECT-1:0] mask,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [NSECT-1:0] first_oh
);
    logic [NSECT:0] seen;

    assign seen[0] = 1'b0;
    for (genvar gi = 0; gi < NSECT; gi++) begin : g_pri
        assign first_oh[gi]  = mask[gi] & ~seen[gi];
        assign seen[gi + 1]  = seen[gi] | mask[gi];
    end

    assign any = seen[NSECT];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NSECT; i++) begin
            if (first_oh[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/flseq_cmdgen.sv
module flseq_cmdgen
    import flseq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int IDX_W  = 3
) (
    input  op_e               op,
    input  logic [2:0]        step,
    input  logic [IDX_W-1:0]  sect,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [7:0]        pdata,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        data,
    output logic              last_fixed
);
    localparam int SECT_SHIFT = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] a_hi, a_lo, a_base;

    assign a_hi   = ADDR_W'(UNLK_HI);
    assign a_lo   = ADDR_W'(UNLK_LO);
    assign a_base = ADDR_W'(sect) << SECT_SHIFT;

    always_comb begin
        unique case (step)
            3'd0: begin addr = a_hi; data = CMD_KEY1; end
            3'd1: begin addr = a_lo; data = CMD_KEY2; end
            3'd2: begin addr = a_hi; data = (op == OP_PROG) ? CMD_PROG : CMD_ESET; end
            3'd3: begin
                if (op == OP_PROG) begin addr = paddr; data = pdata; end
                else               begin addr = a_hi;  data = CMD_KEY1; end
            end
            3'd4: begin addr = a_lo; data = CMD_KEY2; end
            default: begin
                if (op == OP_CHIP) begin addr = a_hi;   data = CMD_CHIP; end
                else               begin addr = a_base; data = CMD_SECT; end
            end
        endcase
    end

    assign last_fixed = ((op == OP_PROG) && (step == 3'd3)) ||
                        ((op == OP_CHIP) && (step == STEP_TAIL));
endmodule

// File: rtl/flseq_poll.sv
module flseq_poll
    import flseq_pkg::*;
#(
    parameter int MAX_POLLS = 4096,
    parameter int CNT_W     = $clog2(MAX_POLLS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)                            cnt <= '0;
        else if (inc && cnt != CNT_W'(MAX_POLLS))  cnt <= cnt + 1'b1;
    end

    assign hit = (cnt == CNT_W'(MAX_POLLS));

    // R8
    poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAX_POLLS));
endmodule

// File: rtl/flseq_top.sv
module flseq_top
    import flseq_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int NSECT     = 8,
    parameter int MAX_POLLS = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic [NSECT-1:0]  req_mask,
    output logic              done,
    output logic              err,
    output logic              tmo,
    output logic              fl_we,
    output logic              fl_rd,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic [7:0]        fl_rdata
);
    localparam int IDX_W      = $clog2(NSECT);
    localparam int SECT_SHIFT = ADDR_W - IDX_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } ctx_t;

    state_e            state;
    ctx_t              ctx;
    logic [NSECT-1:0]  rem;
    logic [2:0]        step;
    logic              last_q;
    logic [ADDR_W-1:0] poll_addr;
    logic              err_q, tmo_q;

    logic              req_any;
    logic [IDX_W-1:0]  req_idx;
    logic [NSECT-1:0]  req_first;
    logic              rem_any;
    logic [IDX_W-1:0]  rem_idx;
    logic [NSECT-1:0]  rem_first;
    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_data;
    logic              cmd_last;
    logic              poll_hit;
    logic              is_sect_cmd, wr_last, complete;
    op_e               req_op_e;

    assign req_op_e = op_e'(req_op);

    flseq_sectpick #(.NSECT(NSECT), .IDX_W(IDX_W)) u_req_pick (
        .mask(req_mask), .any(req_any), .idx(req_idx), .first_oh(req_first));

    flseq_sectpick #(.NSECT(NSECT), .IDX_W(IDX_W)) u_rem_pick (
        .mask(rem), .any(rem_any), .idx(rem_idx), .first_oh(rem_first));

    flseq_cmdgen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cmd (
        .op(ctx.op), .step(step), .sect(rem_idx), .paddr(ctx.addr),
        .pdata(ctx.data), .addr(cmd_addr), .data(cmd_data), .last_fixed(cmd_last));

    flseq_poll #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk(clk), .rst(rst), .clr(state == S_IDLE),
        .inc(state == S_POLL_RD), .hit(poll_hit));

    assign is_sect_cmd = (ctx.op == OP_SECT) && (step == STEP_TAIL);
    assign wr_last     = cmd_last || (is_sect_cmd && ((rem & ~rem_first) == '0));
    assign complete    = poll_done(ctx.op, fl_rdata, ctx.data);

    // Bus side, decoded from the registered state
    always_comb begin
        fl_we    = 1'b0;
        fl_rd    = 1'b0;
        fl_addr  = '0;
        fl_wdata = '0;
        unique case (state)
            S_WR:     begin fl_we = 1'b1; fl_addr = cmd_addr; fl_wdata = cmd_data; end
            S_RST_WR: begin fl_we = 1'b1; fl_wdata = CMD_RESET; end
            S_PRE_RD: begin fl_rd = 1'b1; fl_addr = ctx.addr; end
            S_POLL_RD,
            S_RCK_RD: begin fl_rd = 1'b1; fl_addr = poll_addr; end
            default: ;
        endcase
    end

    assign req_ready = (state == S_IDLE);
    assign done      = (state == S_FIN);
    assign err       = (state == S_FIN) && err_q;
    assign tmo       = (state == S_FIN) && tmo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            ctx       <= '0;
            rem       <= '0;
            step      <= '0;
            last_q    <= 1'b0;
            poll_addr <= '0;
            err_q     <= 1'b0;
            tmo_q     <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    ctx    <= '{op: req_op_e, addr: req_addr, data: req_data};
                    rem    <= req_mask;
                    step   <= '0;
                    last_q <= 1'b0;
                    err_q  <= 1'b0;
                    tmo_q  <= 1'b0;
                    unique case (req_op_e)
                        OP_CHIP: poll_addr <= '0;
                        OP_SECT: poll_addr <= ADDR_W'(req_idx) << SECT_SHIFT;
                        default: poll_addr <= req_addr;
                    endcase
                    if (req_op_e == OP_RSVD || (req_op_e == OP_SECT && !req_any)) begin
                        err_q <= 1'b1;
                        state <= S_FIN;
                    end else if (req_op_e == OP_PROG) begin
                        state <= S_PRE_RD;
                    end else begin
                        state <= S_WR;
                    end
                end
                S_PRE_RD:  state <= S_PRE_CHK;
                S_PRE_CHK: begin
                    if (needs_set(fl_rdata, ctx.data)) begin
                        err_q <= 1'b1;
                        state <= S_FIN;
                    end else begin
                        state <= S_WR;
                    end
                end
                S_WR: begin
                    last_q <= wr_last;
                    if (is_sect_cmd)        rem  <= rem & ~rem_first;
                    if (step != STEP_TAIL)  step <= step + 3'd1;
                    state <= S_GAP;
                end
                S_GAP:     state <= last_q ? S_POLL_RD : S_WR;
                S_POLL_RD: state <= S_POLL_CHK;
                S_POLL_CHK: begin
                    if (complete)          state <= S_FIN;
                    else if (fl_rdata[5])  state <= S_RCK_RD;
                    else if (poll_hit) begin
                        tmo_q <= 1'b1;
                        state <= S_RST_WR;
                    end else               state <= S_POLL_RD;
                end
                S_RCK_RD:  state <= S_RCK_CHK;
                S_RCK_CHK: begin
                    if (complete) state <= S_FIN;
                    else begin
                        err_q <= 1'b1;
                        state <= S_RST_WR;
                    end
                end
                S_RST_WR:  state <= S_FIN;
                default:   state <= S_IDLE;
            endcase
        end
    end

    // Spacing monitor for sector commands (checker state only)
    logic [2:0] since30;
    logic       seen30;
    always_ff @(posedge clk) begin
        if (rst || state == S_IDLE) begin
            since30 <= '0;
            seen30  <= 1'b0;
        end else if (fl_we && fl_wdata == CMD_SECT) begin
            since30 <= '0;
            seen30  <= 1'b1;
        end else if (since30 != 3'd7) begin
            since30 <= since30 + 3'd1;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!fl_we && !fl_rd && !done));
    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_rd));
    // R3
    rsvd_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_op == 2'b11) |=> (done && err));
    // R4
    sect_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_we && fl_wdata == CMD_SECT && seen30) |-> (since30 == 3'd1));
    // R4
    sect_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_WR && is_sect_cmd) |-> rem_any);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));
    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(err && tmo));
endmodule

// File: tb/flseq_top_tb.sv
`timescale 1ns/1ps
module flseq_top_tb_top;
    localparam int AW  = 19;
    localparam int NS  = 8;
    localparam int MXP = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic [NS-1:0] req_mask = '0;
    logic          done, err, tmo, fl_we, fl_rd;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata;
    logic [7:0]    fl_rdata = 8'hFF;

    always #10 clk = ~clk;

    flseq_top #(.ADDR_W(AW), .NSECT(NS), .MAX_POLLS(MXP)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .req_mask(req_mask), .done(done), .err(err), .tmo(tmo),
        .fl_we(fl_we), .fl_rd(fl_rd), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_rdata(fl_rdata));

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural flash stub ----------------
    logic [7:0] mem [int];
    function automatic logic [7:0] mem_rd(int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction

    int          st_op = 0;            // 0 none, 1 program, 2 erase
    logic [7:0]  st_pd;
    logic [7:0]  st_sect;
    int          st_busy = 0;
    bit          st_dq5 = 0;
    int          st_reads = 0;
    bit          tgl = 0;
    logic [26:0] cq[$];
    int          cfg_busy = 0;
    int          cfg_dq5 = 0;          // 0 none, 1 stuck failure, 2 failure flag then finish
    bit          cfg_never = 0;
    int          exp_poll = 0;
    bit          bad_poll = 0;

    task automatic stub_finish();
        if (st_op == 2) begin
            int keys[$];
            foreach (mem[k]) if (st_sect[k >> 16]) keys.push_back(k);
            foreach (keys[j]) mem.delete(keys[j]);
        end
        st_op = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            st_op = 0;
            cq.delete();
        end else begin
            if (fl_we) begin
                if (fl_wdata == 8'hF0) begin
                    st_op = 0;
                    cq.delete();
                end else if (st_op == 2 && st_reads == 0 && fl_wdata == 8'h30) begin
                    st_sect[fl_addr[18:16]] = 1'b1;
                end else if (st_op == 0) begin
                    cq.push_back({fl_addr, fl_wdata});
                    if (cq.size() == 4 && cq[2][7:0] == 8'hA0) begin
                        st_op = 1;
                        st_pd = fl_wdata;
                        mem[int'(fl_addr)] = mem_rd(int'(fl_addr)) & fl_wdata;
                        st_busy = cfg_busy; st_dq5 = 0;
                        cq.delete();
                    end else if (cq.size() == 6) begin
                        st_sect = '0;
                        if (fl_wdata == 8'h10) st_sect = 8'hFF;
                        else st_sect[fl_addr[18:16]] = 1'b1;
                        st_op = 2;
                        st_busy = cfg_busy; st_dq5 = 0;
                        cq.delete();
                    end else if (cq.size() > 6) begin
                        cq.delete();
                    end
                end
            end
            if (fl_rd) begin
                if (st_op != 0) begin
                    st_reads++;
                    tgl = ~tgl;
                    if (int'(fl_addr) != exp_poll) bad_poll = 1;
                    if (cfg_dq5 == 2 && st_dq5) begin
                        stub_finish();
                        fl_rdata <= mem_rd(int'(fl_addr));
                    end else if (cfg_dq5 != 0 || cfg_never || st_busy > 0) begin
                        st_busy--;
                        st_dq5 = (cfg_dq5 != 0);
                        fl_rdata <= {(st_op == 1) ? ~st_pd[7] : 1'b0, tgl, st_dq5, 5'b0};
                    end else begin
                        stub_finish();
                        fl_rdata <= mem_rd(int'(fl_addr));
                    end
                end else begin
                    fl_rdata <= mem_rd(int'(fl_addr));
                end
            end
        end
    end

    // ---------------- expected write stream, compared every cycle ----------------
    logic [26:0] exp_wq[$];
    string       cur_tag = "R2";
    int          last30 = -1;

    always @(negedge clk) begin
        if (!rst && fl_we) begin
            if (exp_wq.size() == 0) begin
                chk(1'b0, cur_tag, "unexpected write", {fl_addr, fl_wdata}, 0);
            end else begin
                logic [26:0] e;
                e = exp_wq.pop_front();
                chk({fl_addr, fl_wdata} == e, cur_tag, "write addr/data",
                    {fl_addr, fl_wdata}, e);
            end
            if (fl_wdata == 8'h30) begin
                if (last30 >= 0)
                    chk(cyc - last30 == 2, "R4", "sector command spacing", cyc - last30, 2);
                last30 = cyc;
            end
        end
    end

    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [7:0] d, input logic [NS-1:0] m,
                          input bit ex_wr, input bit ex_rst, input bit ex_err,
                          input bit ex_tmo, input int ex_reads, input string tag,
                          input bit poke);
        int n;
        exp_wq.delete();
        if (ex_wr) begin
            exp_wq.push_back({19'h05555, 8'hAA});
            exp_wq.push_back({19'h02AAA, 8'h55});
            if (op == 2'b00) begin
                exp_wq.push_back({19'h05555, 8'hA0});
                exp_wq.push_back({a, d});
            end else begin
                exp_wq.push_back({19'h05555, 8'h80});
                exp_wq.push_back({19'h05555, 8'hAA});
                exp_wq.push_back({19'h02AAA, 8'h55});
                if (op == 2'b10) exp_wq.push_back({19'h05555, 8'h10});
                else for (int s = 0; s < NS; s++)
                    if (m[s]) exp_wq.push_back({AW'(s) << 16, 8'h30});
            end
        end
        if (ex_rst) exp_wq.push_back({19'h0, 8'hF0});
        exp_poll = 0;
        if (op == 2'b00) exp_poll = int'(a);
        else if (op == 2'b01)
            for (int s = NS - 1; s >= 0; s--) if (m[s]) exp_poll = s << 16;
        st_reads = 0; bad_poll = 0; last30 = -1; cur_tag = tag;

        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 5000) begin
            if (poke && n == 3) begin
                chk(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
                req_valid = 1'b1; req_op = 2'b10; req_addr = '0; req_mask = 8'hFF;
            end
            if (poke && n == 6) req_valid = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(done, "R10", {tag, " done seen"}, done, 1);
        chk(err == ex_err, tag, "err flag", err, ex_err);
        chk(tmo == ex_tmo, tag, "tmo flag", tmo, ex_tmo);
        chk(exp_wq.size() == 0, tag, "writes left unissued", exp_wq.size(), 0);
        if (ex_reads >= 0) chk(st_reads == ex_reads, tag, "poll reads", st_reads, ex_reads);
        chk(!bad_poll, "R6", "poll address", bad_poll, 0);
        @(negedge clk);
        chk(!done && req_ready, "R10", "single pulse then ready", {done, req_ready}, 1);
        exp_wq.delete();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(1'b0, "WDOG", "run did not end", cyc, 100000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !done && !fl_we && !fl_rd, "R1", "idle after reset",
            {req_ready, done, fl_we, fl_rd}, 4'b1000);

        // R2 R6 program, busy for three reads, bit 7 clear in data
        cfg_busy = 3; cfg_dq5 = 0; cfg_never = 0;
        run_op(2'b00, 19'h12345, 8'h5A, '0, 1, 0, 0, 0, 4, "R2", 0);
        chk(mem_rd(32'h12345) == 8'h5A, "R2", "programmed byte", mem_rd(32'h12345), 8'h5A);
        // R6 program with bit 7 set, done on first read
        cfg_busy = 0;
        run_op(2'b00, 19'h00777, 8'hC3, '0, 1, 0, 0, 0, 1, "R6", 0);

        // R3 refused: needs a 0 to become 1
        run_op(2'b00, 19'h12345, 8'hFF, '0, 0, 0, 1, 0, 0, "R3", 0);
        chk(mem_rd(32'h12345) == 8'h5A, "R3", "byte untouched", mem_rd(32'h12345), 8'h5A);
        // R3 reserved op and empty mask
        run_op(2'b11, 19'h0, 8'h0, '0, 0, 0, 1, 0, 0, "R3", 0);
        run_op(2'b01, 19'h0, 8'h0, '0, 0, 0, 1, 0, 0, "R3", 0);

        // R4 sector erase of 2, 5, 7 with a stray request (R9)
        cfg_busy = 0;
        run_op(2'b00, 19'h50010, 8'h00, '0, 1, 0, 0, 0, 1, "R2", 0);
        cfg_busy = 5;
        run_op(2'b01, 19'h0, 8'h0, 8'b1010_0100, 1, 0, 0, 0, 6, "R4", 1);
        chk(mem_rd(32'h50010) == 8'hFF, "R4", "selected sector erased", mem_rd(32'h50010), 8'hFF);
        chk(mem_rd(32'h12345) == 8'h5A, "R4", "other sector kept", mem_rd(32'h12345), 8'h5A);

        // R5 chip erase
        cfg_busy = 2;
        run_op(2'b10, 19'h0, 8'h0, '0, 1, 0, 0, 0, 3, "R5", 0);
        chk(mem_rd(32'h12345) == 8'hFF, "R5", "chip erased", mem_rd(32'h12345), 8'hFF);

        // R7 failure flag persists: reread, error, reset write
        cfg_busy = 0; cfg_dq5 = 1;
        run_op(2'b00, 19'h20020, 8'h11, '0, 1, 1, 1, 0, 2, "R7", 0);
        // R7 failure flag then finished on reread: success
        cfg_dq5 = 2;
        run_op(2'b00, 19'h20030, 8'h22, '0, 1, 0, 0, 0, 2, "R7", 0);

        // R8 watchdog on a sector erase that never ends
        cfg_dq5 = 0; cfg_never = 1;
        run_op(2'b01, 19'h0, 8'h0, 8'b0000_0010, 1, 1, 0, 1, MXP, "R8", 0);
        cfg_never = 0;

        // R9 stray request on a program leaves the stream unchanged
        cfg_busy = 6;
        run_op(2'b00, 19'h30003, 8'h0F, '0, 1, 0, 0, 0, 7, "R9", 1);

        finish_run();
    end
endmodule